// File: doc/BRIEF.md
# Byte-Framed Serial Control Port

This block is the slave end of a four-wire serial control link. It gives a host access to a bank of 128 eight-bit registers. The four wires are a serial clock, an active-low select, a data input and a data output with its own enable. While select is low the host sends whole bytes, most significant bit first. The first byte is a command and every byte after it is data for that command. A write command stores the data bytes that follow into consecutive registers. A read command makes the port return a fixed identification byte, 0x81, and then the register contents from the requested address upward.

The three serial inputs are brought into a faster system clock through two-flop synchronisers. Serial clock and select edges are detected in that domain. Input bits are taken on detected rising edges of the serial clock. The output bit and its enable are updated on detected falling edges. Only one command is accepted per select-low window. Raising select ends the transfer at once, at any bit.

Top module: `sctl_port`

## Requirements
- R1: Bytes are framed MSB first from the select fall. In the first byte, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6:0 give the starting register address.
- R2: `sdi` is sampled only on rising serial-clock edges. `sdo` changes only after a falling serial-clock edge and holds its value through the high phase.
- R3: The data bytes of a write go to registers at the start address, start+1, and so on. The address wraps from 127 to 0. Each byte is stored only after its eighth rising edge.
- R4: After a read command, the first byte shifted out is 0x81. It is followed by the registers at the start address, start+1, and so on, with the same wrap.
- R5: While read data is being sent, input bytes are neither decoded as commands nor written to any register. The read stream continues unaffected.
- R6: `sdo_oe` is high only while read output is being driven. It is low after reset, during the whole command byte and during writes.
- R7: Raising select at any bit aborts the transfer. `sdo_oe` falls, a partial write byte is discarded, and bytes already completed stay written.
- R8: All 128 registers read as zero after reset.
- R9: Within a write window, later bytes whose bit 7 is set are stored as data and never taken as a new command.
- R10: Operation is correct for any serial-clock duty cycle in which each high and each low phase lasts at least 4 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low select framing one command |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The bench drives writes that cross the top of the address space. A design that failed to wrap would write register 128, or would leave register 0 unchanged, and the read-back would show it. It puts a complete write command on `sdi` during a read. A design that still decoded input in that state would change register 0x30 or break the reply stream. It aborts one write in the middle of a byte and one read in the middle of the identification byte. It checks that the partial byte never lands and that the output enable drops. It also writes data bytes with bit 7 set, which a design that allowed several commands per window would take as reads. Finally, it runs strongly asymmetric clock duty cycles, which would expose an output updated on the wrong edge or sampled too early after synchronisation.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = BYTE_W - 1;
    localparam int REG_COUNT = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  BIT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] ID_CODE  = 8'h81;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_READ
    } sctl_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } sctl_cmd_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } sctl_wr_t;

    function automatic sctl_cmd_t sctl_decode(input logic [BYTE_W-1:0] b);
        sctl_cmd_t c;
        c.rd   = b[BYTE_W-1];
        c.addr = b[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] sctl_next(input logic [ADDR_W-1:0] a);
        return a + 1'b1;
    endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= din;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_det
        assign rise[i] = din[i] & ~prev[i];
        assign fall[i] = ~din[i] & prev[i];
    end
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sctl_wr_t          wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BYTE_W-1:0] mem [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr.en && (wr.addr == ADDR_W'(i)))
                mem[i] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> mem[$past(wr.addr)] == $past(wr.data)); // R3
endmodule

// File: rtl/sctl_engine.sv
module sctl_engine
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel_start,
    input  logic              sel_stop,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output sctl_wr_t          wr,
    output logic              sdo,
    output logic              sdo_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    sctl_state_e       state;
    logic [BYTE_W-2:0] rx_sh;
    logic [CNT_W-1:0]  rx_cnt;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  tx_cnt;
    logic [ADDR_W-1:0] ptr;

    logic [BYTE_W-1:0] rx_byte;
    logic              rx_last;
    logic              tx_last;
    sctl_cmd_t         cmd;

    assign rx_byte = {rx_sh, sdi_s};
    assign rx_last = (rx_cnt == BIT_LAST);
    assign tx_last = (tx_cnt == BIT_LAST);
    assign cmd     = sctl_decode(rx_byte);
    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rx_sh  <= '0;
            rx_cnt <= '0;
            tx_sh  <= '0;
            tx_cnt <= '0;
            ptr    <= '0;
            wr     <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else begin
            wr.en <= 1'b0;
            if (sel_stop) begin
                state  <= ST_IDLE;
                sdo_oe <= 1'b0;
                rx_cnt <= '0;
            end else if (sel_start) begin
                state  <= ST_CMD;
                sdo_oe <= 1'b0;
                rx_cnt <= '0;
            end else begin
                unique case (state)
                    ST_CMD: begin
                        if (sclk_rise) begin
                            rx_sh  <= rx_byte[BYTE_W-2:0];
                            rx_cnt <= rx_cnt + 1'b1;
                            if (rx_last) begin
                                ptr <= cmd.addr;
                                if (cmd.rd) begin
                                    state  <= ST_READ;
                                    tx_sh  <= ID_CODE;
                                    tx_cnt <= '0;
                                end else begin
                                    state  <= ST_WRITE;
                                end
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (sclk_rise) begin
                            rx_sh  <= rx_byte[BYTE_W-2:0];
                            rx_cnt <= rx_cnt + 1'b1;
                            if (rx_last) begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= rx_byte;
                                ptr     <= sctl_next(ptr);
                            end
                        end
                    end
                    ST_READ: begin
                        if (sclk_fall) begin
                            sdo    <= tx_sh[BYTE_W-1];
                            sdo_oe <= 1'b1;
                            if (tx_last) begin
                                tx_sh  <= rd_data;
                                tx_cnt <= '0;
                                ptr    <= sctl_next(ptr);
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                tx_cnt <= tx_cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_CMD_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD) |-> !sdo_oe); // R6
    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (state == ST_READ)); // R6
    AST_OE_STOP: assert property (@(posedge clk) disable iff (rst)
        sel_stop |=> !sdo_oe); // R7
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(sdo)); // R2
    AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ($past(state) == ST_WRITE)); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (ptr == sctl_next(wr.addr))); // R3
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sel_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int                PIN_N   = 3;
    localparam logic [PIN_N-1:0]  PIN_RST = 3'b010;

    logic [PIN_N-1:0]  pin_s;
    logic [1:0]        rise;
    logic [1:0]        fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    sctl_wr_t          wr;

    sctl_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sdi, sel_n, sclk}),
        .dout(pin_s)
    );

    sctl_edge #(
        .WIDTH  (2),
        .RST_VAL(PIN_RST[1:0])
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .din (pin_s[1:0]),
        .rise(rise),
        .fall(fall)
    );

    sctl_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .sclk_rise(rise[0]),
        .sclk_fall(fall[0]),
        .sel_start(fall[1]),
        .sel_stop (rise[1]),
        .sdi_s    (pin_s[2]),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr       (wr),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    sctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;

    int errors = 0;
    int checks = 0;
    int hi_t = 4;
    int lo_t = 5;
    logic [7:0] model [128];

    // {rd, addr[6:0], count[2:0], four data bytes MSB first}
    localparam int NV = 7;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 7'h10, 3'd3, 32'h11223300},
        {1'b1, 7'h10, 3'd3, 32'h00000000},
        {1'b0, 7'h7E, 3'd3, 32'hA55AC300},
        {1'b1, 7'h7E, 3'd3, 32'h00000000},
        {1'b0, 7'h40, 3'd2, 32'h81C50000},
        {1'b1, 7'h40, 3'd2, 32'h00000000},
        {1'b1, 7'h0F, 3'd2, 32'h00000000}
    };

    sctl_port u_sctl_port (
        .clk   (clk),
        .rst   (rst),
        .sclk  (sclk),
        .sel_n (sel_n),
        .sdi   (sdi),
        .sdo   (sdo),
        .sdo_oe(sdo_oe)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic din, output logic q, output logic qoe, inout logic stable);
        sdi  = din;
        sclk = 1'b0;
        wait_clk(lo_t);
        q    = sdo;
        qoe  = sdo_oe;
        sclk = 1'b1;
        wait_clk(hi_t);
        if (sdo !== q) stable = 1'b0;
    endtask

    task automatic bits_x(input logic [7:0] din, input int nbits, output logic [7:0] dout,
                          output logic oe_all, output logic oe_any, output logic stable);
        logic q, o;
        dout = '0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        stable = 1'b1;
        for (int i = 7; i >= 8 - nbits; i--) begin
            bit_x(din[i], q, o, stable);
            dout[i] = q;
            oe_all &= o;
            oe_any |= o;
        end
    endtask

    task automatic open_win();
        sclk  = 1'b0;
        sel_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic close_win();
        sclk = 1'b0;
        wait_clk(4);
        sel_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic wr_txn(input logic [6:0] addr, input int n, input logic [31:0] data, input string tag);
        logic [7:0] d;
        logic all, any, st, any_seen;
        any_seen = 1'b0;
        open_win();
        bits_x({1'b0, addr}, 8, d, all, any, st);
        any_seen |= any;
        for (int i = 0; i < n; i++) begin
            bits_x(data[31-8*i -: 8], 8, d, all, any, st);
            any_seen |= any;
            model[7'(addr + 7'(i))] = data[31-8*i -: 8];
        end
        close_win();
        check(!any_seen, {tag, " R6 oe low during write"}, 32'(any_seen), 0);
    endtask

    task automatic rd_txn(input logic [6:0] addr, input int n, input string tag);
        logic [7:0] d;
        logic all, any, st;
        open_win();
        bits_x({1'b1, addr}, 8, d, all, any, st);
        check(!any, {tag, " R6 oe low in command byte"}, 32'(any), 0);
        bits_x(8'h00, 8, d, all, any, st);
        check(d == 8'h81, {tag, " R1 R4 id byte"}, 32'(d), 32'h81);
        check(all, {tag, " R6 oe high on reply"}, 32'(all), 1);
        check(st, {tag, " R2 sdo steady in high phase"}, 32'(st), 1);
        for (int i = 0; i < n; i++) begin
            bits_x(8'h00, 8, d, all, any, st);
            check(d == model[7'(addr + 7'(i))], {tag, " R3 R4 read data"}, 32'(d), 32'(model[7'(addr + 7'(i))]));
        end
        close_win();
    endtask

    initial begin
        logic [7:0] d;
        logic all, any, st;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        check(sdo_oe == 1'b0, "R6 oe after reset", 32'(sdo_oe), 0);
        check(sdo == 1'b0, "R6 sdo after reset", 32'(sdo), 0);
        rd_txn(7'h05, 2, "R8 reset contents");

        // table walk; duty cycle varies per vector (R10)
        for (int v = 0; v < NV; v++) begin
            hi_t = 4 + (v % 3);
            lo_t = 4 + ((v * 2) % 5);
            if (VEC[v][42])
                rd_txn(VEC[v][41:35], int'(VEC[v][34:32]), "R9 R10 vector read");
            else
                wr_txn(VEC[v][41:35], int'(VEC[v][34:32]), VEC[v][31:0], "R3 vector write");
        end

        // R10 strongly asymmetric duty cycles
        hi_t = 4;  lo_t = 14;
        rd_txn(7'h7E, 3, "R10 short high");
        hi_t = 15; lo_t = 4;
        rd_txn(7'h10, 3, "R10 short low");
        hi_t = 5;  lo_t = 5;

        // R5 input ignored while reply is shifted out
        open_win();
        bits_x(8'h90, 8, d, all, any, st);
        bits_x(8'h30, 8, d, all, any, st);
        check(d == 8'h81, "R5 id under input noise", 32'(d), 32'h81);
        bits_x(8'hEE, 8, d, all, any, st);
        check(d == model[7'h10], "R5 data under input noise", 32'(d), 32'(model[7'h10]));
        bits_x(8'hFF, 8, d, all, any, st);
        check(d == model[7'h11], "R5 stream continues", 32'(d), 32'(model[7'h11]));
        close_win();
        rd_txn(7'h30, 2, "R5 no write from ignored input");

        // R7 abort during a read, mid identification byte
        open_win();
        bits_x(8'h90, 8, d, all, any, st);
        bits_x(8'h00, 3, d, all, any, st);
        check(sdo_oe == 1'b1, "R7 oe before abort", 32'(sdo_oe), 1);
        sel_n = 1'b1;
        wait_clk(5);
        check(sdo_oe == 1'b0, "R7 oe after abort", 32'(sdo_oe), 0);
        sclk = 1'b0;
        wait_clk(6);

        // R7 abort during a write, partial second data byte
        open_win();
        bits_x(8'h20, 8, d, all, any, st);
        bits_x(8'h5A, 8, d, all, any, st);
        bits_x(8'hFF, 5, d, all, any, st);
        sel_n = 1'b1;
        wait_clk(5);
        sclk = 1'b0;
        wait_clk(6);
        model[7'h20] = 8'h5A;
        rd_txn(7'h20, 2, "R7 partial byte discarded");

        summary();
        $finish;
    end
endmodule